// File: doc/BRIEF.md
# S/PDIF Receiver Lock-Acquisition Controller

This block brings a biphase-mark audio receiver into lock with its serial input. A fast local clock samples the line. The line first passes through a two-flop synchronizer, and an edge detector then finds each transition. Each synchronization attempt measures the widths of the pulses between transitions over a window of 64 pulses. The narrowest pulse is taken as one unit interval (UI). The widest pulse should be a three-UI preamble pulse. An attempt succeeds when the widest pulse is three times the narrowest, within a quarter of the narrowest. The controller then publishes two decision thresholds that a downstream decoder uses to sort pulses into one-, two- and three-UI classes.

A two-bit enable field selects the operating mode. Zero leaves the controller idle. One synchronizes and then holds in a locked state. Three synchronizes and then hands over to reception. The controller can also wait for line activity before it starts measuring. When an attempt fails, the controller retries until a programmable budget runs out. It then raises a sticky timeout error that software can poll to find a dead or unusable line.

The local clock has to run at least 704 times the highest sample rate to be supported. At that ratio a three-UI pulse is about 17 clocks long. The 8-bit width counters therefore have ample headroom, and they saturate rather than wrap.

Top module: `spdif_sync_ctrl`

## Requirements
- R1: The state output encodes 0 idle, 1 waiting for activity, 2 measuring, 3 locked, 4 receiving and 5 failed. The enable field value 2'b01 ends a successful attempt in state 3, and 2'b11 ends it in state 4. The values 2'b00 and 2'b10 keep the block in state 0. Raising the enable field from 2'b01 to 2'b11 while in state 3 moves the block to state 4.
- R2: With the wait-for-activity flag at 1, the block stays in state 1 for as long as the line is still, and it does not raise the error. Once the line toggles, it moves on to measurement and can lock.
- R3: With the wait-for-activity flag at 0, the block enters state 2 on the first clock edge after the enable field becomes 2'b01 or 2'b11.
- R4: The retry field sets the attempt budget: 0 gives 1 attempt, 1 gives 4, 2 gives 16 and 3 gives 64.
- R5: An attempt ends after 64 measured pulses. It succeeds only if 9×min ≤ 4×max ≤ 15×min. A line carrying only one- and two-UI pulses never locks.
- R6: On success, the short threshold output is min + floor(min/2) and the long threshold output is 2×min + floor(min/2). Both are zero in state 0.
- R7: The sync-done output is high for exactly one cycle for each successful lock, and it is never high outside states 3 and 4.
- R8: An attempt that has not seen 64 pulses within 2^TOUT_W sample clocks fails. When the attempt budget is used up, the block enters state 5 and sets the timeout error.
- R9: Setting the enable field to 2'b00 returns the block to state 0, clears the attempt count and zeroes both thresholds, but leaves the timeout error untouched. Only the error-clear input clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial input line |
| mode_en | input | 2 | Enable field: 00 off, 01 lock only, 11 lock then receive |
| retry_sel | input | 2 | Attempt budget select, 1/4/16/64 attempts |
| wait_act | input | 1 | Wait for line activity before measuring |
| err_clr | input | 1 | Clears the sticky timeout error |
| state_o | output | 3 | Controller state code |
| sync_done | output | 1 | One-cycle pulse on successful lock |
| timeout_err | output | 1 | Sticky error: attempt budget used up |
| thr_short | output | CNT_W+2 | Boundary between one- and two-UI pulses |
| thr_long | output | CNT_W+2 | Boundary between two- and three-UI pulses |

## Verification
The embedded properties assume that the retry field stays constant while an attempt sequence runs, because the budget check compares the live field against the attempt count. They also assume that reset is applied before any mode is selected. The stimulus meets both assumptions: it changes the retry field and the line pattern only while the enable field is 2'b00, and it waits long enough for any partial pulse of the old pattern to finish. It toggles the line on the falling clock edge at whole multiples of the clock period. Every measured width is therefore an exact multiple of the unit interval, and the expected thresholds follow directly from that interval.

// File: rtl/spdif_sync_pkg.sv
package spdif_sync_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_MEAS = 3'd2,
    ST_LOCK = 3'd3,
    ST_RECV = 3'd4,
    ST_FAIL = 3'd5
  } sync_state_t;

  localparam logic [1:0] EN_SYNC = 2'b01;
  localparam logic [1:0] EN_FULL = 2'b11;

endpackage

// File: rtl/spdif_line_sync.sv
module spdif_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic edge_o
);

  localparam int SH_W = SYNC_STAGES + 1;

  // Synchronizer stages followed by one history flop for edge detection
  logic [SH_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[SH_W-2:0], line_i};
  end

  assign edge_o = shift_q[SH_W-1] ^ shift_q[SH_W-2];

endmodule

// File: rtl/spdif_pulse_meter.sv
module spdif_pulse_meter #(
  parameter int CNT_W      = 8,
  parameter int TOUT_W     = 16,
  parameter int WIN_PULSES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             edge_i,
  output logic             done_o,
  output logic             ok_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);

  localparam int NP_W = $clog2(WIN_PULSES + 1);
  localparam int EX_W = CNT_W + 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [NP_W-1:0]  NP_LAST = NP_W'(WIN_PULSES - 1);

  logic [CNT_W-1:0]  run_cnt, min_r, max_r, nmin, nmax;
  logic [NP_W-1:0]   npulse;
  logic [TOUT_W-1:0] tcnt;
  logic              seen, fin;
  logic [EX_W-1:0]   min_x9, min_x15, max_x4;
  logic              last_pulse, ratio_ok;

  // Running extremes, including the pulse closed by this cycle's edge
  always_comb begin
    nmin = min_r;
    nmax = max_r;
    if (edge_i && seen) begin
      if (run_cnt < min_r) nmin = run_cnt;
      if (run_cnt > max_r) nmax = run_cnt;
    end
    min_x9   = (EX_W'(nmin) << 3) + EX_W'(nmin);
    min_x15  = (EX_W'(nmin) << 4) - EX_W'(nmin);
    max_x4   = EX_W'(nmax) << 2;
    ratio_ok = (max_x4 >= min_x9) && (max_x4 <= min_x15);
  end

  assign last_pulse = edge_i && seen && (npulse == NP_LAST);

  always_ff @(posedge clk) begin
    if (rst || start_i || !run_i) begin
      run_cnt <= '0;
      min_r   <= CNT_MAX;
      max_r   <= '0;
      npulse  <= '0;
      tcnt    <= '0;
      seen    <= 1'b0;
      fin     <= 1'b0;
      done_o  <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      if (!fin) begin
        tcnt  <= tcnt + 1'b1;
        min_r <= nmin;
        max_r <= nmax;
        if (edge_i) begin
          run_cnt <= CNT_W'(1);
          seen    <= 1'b1;
          if (seen) npulse <= npulse + 1'b1;
        end else if (run_cnt != CNT_MAX) begin
          run_cnt <= run_cnt + 1'b1;
        end
        if (last_pulse) begin
          fin    <= 1'b1;
          done_o <= 1'b1;
          ok_o   <= ratio_ok;
        end else if (&tcnt) begin
          fin    <= 1'b1;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign min_o = min_r;
  assign max_o = max_r;

  // R5
  ok_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> done_o);

  // R8
  single_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/spdif_sync_fsm.sv
module spdif_sync_fsm
  import spdif_sync_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ATT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_en,
  input  logic [1:0]       retry_sel,
  input  logic             wait_act,
  input  logic             err_clr,
  input  logic             edge_i,
  input  logic             m_done,
  input  logic             m_ok,
  input  logic [CNT_W-1:0] m_min,
  output logic             m_run,
  output logic             m_start,
  output sync_state_t      state,
  output logic             sync_done,
  output logic             timeout_err,
  output logic [CNT_W+1:0] thr_short,
  output logic [CNT_W+1:0] thr_long
);

  localparam int THR_W = CNT_W + 2;

  logic [ATT_W-1:0] budget, attempts, att_next;
  logic             act_seen;
  logic             mode_on;

  always_comb begin
    case (retry_sel)
      2'd0:    budget = ATT_W'(1);
      2'd1:    budget = ATT_W'(4);
      2'd2:    budget = ATT_W'(16);
      default: budget = ATT_W'(64);
    endcase
  end

  assign att_next = attempts + 1'b1;
  assign mode_on  = (mode_en == EN_SYNC) || (mode_en == EN_FULL);
  assign m_run    = (state == ST_MEAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      attempts    <= '0;
      act_seen    <= 1'b0;
      thr_short   <= '0;
      thr_long    <= '0;
      sync_done   <= 1'b0;
      timeout_err <= 1'b0;
      m_start     <= 1'b0;
    end else begin
      sync_done <= 1'b0;
      m_start   <= 1'b0;
      if (err_clr) timeout_err <= 1'b0;
      if (!mode_on) begin
        state     <= ST_IDLE;
        attempts  <= '0;
        act_seen  <= 1'b0;
        thr_short <= '0;
        thr_long  <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            act_seen <= 1'b0;
            if (wait_act) begin
              state <= ST_WAIT;
            end else begin
              state   <= ST_MEAS;
              m_start <= 1'b1;
            end
          end
          ST_WAIT: begin
            if (edge_i) begin
              if (act_seen) begin
                state   <= ST_MEAS;
                m_start <= 1'b1;
              end else begin
                act_seen <= 1'b1;
              end
            end
          end
          ST_MEAS: begin
            if (m_done) begin
              if (m_ok) begin
                thr_short <= THR_W'(m_min) + THR_W'(m_min >> 1);
                thr_long  <= (THR_W'(m_min) << 1) + THR_W'(m_min >> 1);
                sync_done <= 1'b1;
                state     <= (mode_en == EN_FULL) ? ST_RECV : ST_LOCK;
              end else begin
                attempts <= att_next;
                if (att_next >= budget) begin
                  state       <= ST_FAIL;
                  timeout_err <= 1'b1;
                end else begin
                  m_start <= 1'b1;
                end
              end
            end
          end
          ST_LOCK: if (mode_en == EN_FULL) state <= ST_RECV;
          ST_RECV: state <= ST_RECV;
          ST_FAIL: state <= ST_FAIL;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sync_done |=> !sync_done);

  // R7
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    sync_done |-> (state == ST_LOCK || state == ST_RECV));

  // R8
  err_in_fail_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> state == ST_FAIL);

  // R4
  budget_limit_chk: assert property (@(posedge clk) disable iff (rst)
    attempts <= budget);

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> (thr_short == '0 && thr_long == '0 && attempts == '0));

endmodule

// File: rtl/spdif_sync_ctrl.sv
module spdif_sync_ctrl
  import spdif_sync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TOUT_W      = 16,
  parameter int WIN_PULSES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic [1:0]       mode_en,
  input  logic [1:0]       retry_sel,
  input  logic             wait_act,
  input  logic             err_clr,
  output logic [2:0]       state_o,
  output logic             sync_done,
  output logic             timeout_err,
  output logic [CNT_W+1:0] thr_short,
  output logic [CNT_W+1:0] thr_long
);

  logic             line_edge;
  logic             m_run, m_start, m_done, m_ok;
  logic [CNT_W-1:0] m_min, m_max;
  sync_state_t      state;

  spdif_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .line_i (line_in),
    .edge_o (line_edge)
  );

  spdif_pulse_meter #(
    .CNT_W      (CNT_W),
    .TOUT_W     (TOUT_W),
    .WIN_PULSES (WIN_PULSES)
  ) u_meter (
    .clk     (clk),
    .rst     (rst),
    .run_i   (m_run),
    .start_i (m_start),
    .edge_i  (line_edge),
    .done_o  (m_done),
    .ok_o    (m_ok),
    .min_o   (m_min),
    .max_o   (m_max)
  );

  spdif_sync_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .mode_en     (mode_en),
    .retry_sel   (retry_sel),
    .wait_act    (wait_act),
    .err_clr     (err_clr),
    .edge_i      (line_edge),
    .m_done      (m_done),
    .m_ok        (m_ok),
    .m_min       (m_min),
    .m_run       (m_run),
    .m_start     (m_start),
    .state       (state),
    .sync_done   (sync_done),
    .timeout_err (timeout_err),
    .thr_short   (thr_short),
    .thr_long    (thr_long)
  );

  assign state_o = state;

  // R5
  extremes_order_chk: assert property (@(posedge clk) disable iff (rst)
    m_ok |-> m_max > m_min);

endmodule

// File: tb/spdif_sync_ctrl_bench.sv
module spdif_sync_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int TOUT_W     = 10;
  localparam int TOUT       = 1 << TOUT_W;
  localparam int THR_W      = CNT_W + 2;
  localparam int NVEC       = 6;

  logic             clk = 1'b0;
  logic             rst;
  logic             line_in;
  logic [1:0]       mode_en;
  logic [1:0]       retry_sel;
  logic             wait_act;
  logic             err_clr;
  logic [2:0]       state_o;
  logic             sync_done;
  logic             timeout_err;
  logic [THR_W-1:0] thr_short, thr_long;

  int  n_chk = 0;
  int  n_fail = 0;
  int  done_total = 0;
  int  ui = 4;
  bit  has3 = 1'b1;
  bit  line_act = 1'b0;

  typedef struct packed {
    logic [3:0] ui;
    logic       has3;
    logic       active;
    logic       wact;
    logic [1:0] mode;
    logic [1:0] rsel;
    logic [2:0] st;
    logic       err;
    logic [9:0] ts;
    logic [9:0] tl;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd4, 1'b1, 1'b1, 1'b0, 2'b01, 2'd0, 3'd3, 1'b0, 10'd6, 10'd10},
    '{4'd5, 1'b1, 1'b1, 1'b0, 2'b11, 2'd0, 3'd4, 1'b0, 10'd7, 10'd12},
    '{4'd6, 1'b1, 1'b1, 1'b1, 2'b01, 2'd0, 3'd3, 1'b0, 10'd9, 10'd15},
    '{4'd4, 1'b0, 1'b1, 1'b0, 2'b01, 2'd1, 3'd5, 1'b1, 10'd0, 10'd0},
    '{4'd3, 1'b1, 1'b1, 1'b0, 2'b11, 2'd0, 3'd4, 1'b0, 10'd4, 10'd7},
    '{4'd5, 1'b1, 1'b0, 1'b0, 2'b01, 2'd0, 3'd5, 1'b1, 10'd0, 10'd0}
  };

  spdif_sync_ctrl #(.CNT_W(CNT_W), .TOUT_W(TOUT_W)) u_spdif_sync_ctrl (
    .clk         (clk),
    .rst         (rst),
    .line_in     (line_in),
    .mode_en     (mode_en),
    .retry_sel   (retry_sel),
    .wait_act    (wait_act),
    .err_clr     (err_clr),
    .state_o     (state_o),
    .sync_done   (sync_done),
    .timeout_err (timeout_err),
    .thr_short   (thr_short),
    .thr_long    (thr_long)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (sync_done) done_total <= done_total + 1;

  function automatic int pulse_w(input int k, input bit with3);
    case (k)
      0:       return with3 ? 3 : 2;
      3, 5:    return 2;
      default: return 1;
    endcase
  endfunction

  // Line driver: repeating frame-like pulse pattern in units of ui
  initial begin
    line_in = 1'b0;
    forever begin
      if (line_act) begin
        for (int k = 0; k < 8; k++) begin
          repeat (ui * pulse_w(k, has3)) @(negedge clk);
          line_in = ~line_in;
        end
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (state_o == 3'd3 || state_o == 3'd4 || state_o == 3'd5) break;
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    mode_en = 2'b00;
    err_clr = 1'b1;
    cycles(1);
    err_clr = 1'b0;
    cycles(150);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int d0;
    rst = 1'b1; mode_en = 2'b00; retry_sel = 2'd0; wait_act = 1'b0; err_clr = 1'b0;
    cycles(4);
    rst = 1'b0;
    cycles(2);
    // R1 reset state
    check_eq("R1 reset state", state_o, 0);
    check_eq("R8 reset error", timeout_err, 0);
    check_eq("R6 reset short thr", thr_short, 0);
    check_eq("R7 reset sync_done", sync_done, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      go_idle();
      ui = VECS[v].ui; has3 = VECS[v].has3; line_act = VECS[v].active;
      retry_sel = VECS[v].rsel; wait_act = VECS[v].wact;
      cycles(150);
      d0 = done_total;
      mode_en = VECS[v].mode;
      settle(20000);
      cycles(3);
      check_eq("R1/R5 vec state", state_o, VECS[v].st);
      check_eq("R8 vec error", timeout_err, VECS[v].err);
      check_eq("R6 vec short thr", thr_short, VECS[v].ts);
      check_eq("R6 vec long thr", thr_long, VECS[v].tl);
      check_eq("R7 vec sync_done pulses", done_total - d0, VECS[v].err ? 0 : 1);
    end

    // R3: immediate start without wait-for-activity
    go_idle();
    ui = 4; has3 = 1'b1; line_act = 1'b1; wait_act = 1'b0; retry_sel = 2'd0;
    cycles(150);
    mode_en = 2'b01;
    cycles(1);
    check_eq("R3 measuring next cycle", state_o, 2);

    // R2: still line with wait flag stays waiting, no error
    go_idle();
    line_act = 1'b0; wait_act = 1'b1; retry_sel = 2'd0;
    cycles(150);
    mode_en = 2'b01;
    cycles(3 * TOUT);
    check_eq("R2 waiting on still line", state_o, 1);
    check_eq("R2 no error while waiting", timeout_err, 0);
    line_act = 1'b1;
    settle(5000);
    cycles(2);
    check_eq("R2 lock after activity", state_o, 3);

    // R1: raising enable to full receive from locked
    mode_en = 2'b11;
    cycles(2);
    check_eq("R1 locked to receive", state_o, 4);

    // R9: disable clears thresholds, state
    mode_en = 2'b00;
    cycles(2);
    check_eq("R9 idle after disable", state_o, 0);
    check_eq("R9 short thr cleared", thr_short, 0);
    check_eq("R9 long thr cleared", thr_long, 0);

    // R1: value 2'b10 stays idle
    wait_act = 1'b0;
    mode_en = 2'b10;
    cycles(300);
    check_eq("R1 mode 10 idle", state_o, 0);
    check_eq("R7 no sync_done in mode 10", sync_done, 0);

    // R4/R8: dead line, budget of 4 attempts
    go_idle();
    line_act = 1'b0; wait_act = 1'b0; retry_sel = 2'd1;
    cycles(150);
    mode_en = 2'b01;
    cycles(3 * TOUT + TOUT / 2);
    check_eq("R4 sel1 no error before 4th attempt ends", timeout_err, 0);
    check_eq("R4 sel1 still measuring", state_o, 2);
    cycles(TOUT);
    check_eq("R4 sel1 error after 4 attempts", timeout_err, 1);
    check_eq("R8 failed state", state_o, 5);

    // R9: disable keeps error, err_clr clears it
    mode_en = 2'b00;
    cycles(3);
    check_eq("R9 error held after disable", timeout_err, 1);
    check_eq("R9 idle after disable from fail", state_o, 0);
    err_clr = 1'b1;
    cycles(1);
    err_clr = 1'b0;
    cycles(1);
    check_eq("R9 error cleared", timeout_err, 0);

    // R4: budget of 16 attempts
    go_idle();
    retry_sel = 2'd2;
    cycles(150);
    mode_en = 2'b01;
    cycles(15 * TOUT + TOUT / 2);
    check_eq("R4 sel2 no error before 16th attempt ends", timeout_err, 0);
    cycles(TOUT);
    check_eq("R4 sel2 error after 16 attempts", timeout_err, 1);

    mode_en = 2'b00;
    cycles(2);
    summary();
    $finish;
  end

endmodule